// File: doc/BRIEF.md
# Endian-Selectable Byte Stream Packer

This block sits between an 8-bit byte stream and a 32-bit word bus. Inbound, it collects stream bytes into words. Each byte is placed on a lane chosen by a big/little orientation input, and each word carries a byte-enable mask. Outbound, it takes a word and its enables and sends the enabled bytes out as a stream. The stream order is the same in both orientations: the lowest address goes first. Only the lane that an address occupies changes with the orientation.

A third, purely combinational path handles sub-word slave accesses to a register file. It remaps the byte address within the word, so each register stays on its physical lane whatever the orientation. All-word accesses pass through unchanged.

Both stream and word sides use valid/ready handshakes. The orientation is sampled when a transfer starts in each direction, so a change in the middle of a transfer takes effect only from the next one.

Top module: `endian_lane_packer`

## Requirements
- R1: After a synchronous active-high reset, `pk_valid` and `so_valid` are low, and `in_ready` and `un_ready` are high.
- R2: With `big_mode` low, the byte at address offset k within a word is placed on lane k, meaning bits 8k+7..8k of `pk_data`, and `pk_be[k]` is set.
- R3: With `big_mode` high, the byte at address offset k is placed on lane 3-k. Successive stream bytes therefore fill descending lanes.
- R4: A word is emitted on `pk_*` in the cycle after the byte at offset 3 is accepted, or after a byte flagged by `in_last` is accepted. A partial word carries enables only for the lanes that were filled, and its unfilled lanes read zero.
- R5: `in_start_off` (0 to 3) is sampled only with the first byte of a transfer, and gives that byte's address offset. Later bytes take ascending addresses, and every later word starts at offset 0.
- R6: The unpacker sends only the enabled bytes of an accepted word, in ascending address order, with lane = offset (little) or 3 - offset (big). `so_last` marks the final byte. A word with all enables clear produces no output.
- R7: The orientation is captured with the first byte of an inbound transfer and with each accepted outbound word. Changes to `big_mode` after that capture have no effect on that transfer.
- R8: `sl_lane_addr` equals `sl_addr` when `big_mode` is low, or when `sl_size` is 2 or 3 (a full word). When `big_mode` is high, a byte access (`sl_size`=0) gives `sl_addr` XOR 3, and a halfword access (`sl_size`=1) gives `sl_addr` XOR 2.
- R9: `pk_data`, `pk_be` and `so_byte` hold steady while their valid is high and ready is low. `in_ready` is low while `pk_valid` is high, and `un_ready` is low while bytes of a word remain to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_mode | input | 1 | 1 selects big-endian lane order, 0 selects little-endian |
| in_valid | input | 1 | Inbound stream byte valid |
| in_ready | output | 1 | Inbound stream byte accepted |
| in_byte | input | 8 | Inbound stream byte |
| in_last | input | 1 | Byte ends the transfer |
| in_start_off | input | 2 | Address offset of the first byte of a transfer |
| pk_valid | output | 1 | Packed word valid |
| pk_ready | input | 1 | Packed word taken |
| pk_data | output | 32 | Packed word |
| pk_be | output | 4 | Byte enables of the packed word |
| un_valid | input | 1 | Outbound word valid |
| un_ready | output | 1 | Outbound word accepted |
| un_data | input | 32 | Outbound word |
| un_be | input | 4 | Byte enables of the outbound word |
| so_valid | output | 1 | Outbound stream byte valid |
| so_ready | input | 1 | Outbound stream byte taken |
| so_byte | output | 8 | Outbound stream byte |
| so_last | output | 1 | Final byte of the current word |
| sl_addr | input | 2 | Slave byte address within the word |
| sl_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| sl_lane_addr | output | 2 | Remapped byte address |

## Verification
The packed word is due one clock after the edge that accepts its completing byte, so the bench checks `pk_*` at the falling edge right after that edge. It also checks that `pk_*` is low again one cycle after the word is taken. The first outbound byte is registered and appears one clock after the edge that accepts its word. Each later byte appears one clock after the edge where `so_ready` took the previous byte, and the bench samples at every falling edge in between, including the stalled ones. The slave address remap is combinational, so it is checked a short delay after its inputs are driven, within the same cycle.

// File: rtl/elp_pkg.sv
package elp_pkg;
  localparam int LANES = 4;
  localparam int BW    = 8;
  localparam int OW    = $clog2(LANES);

  // address offset -> physical lane under the chosen orientation
  function automatic logic [OW-1:0] lane_of(input logic [OW-1:0] off, input logic big);
    return big ? OW'(LANES-1) - off : off;
  endfunction

  // lowest address offset whose lane is still enabled
  function automatic logic [OW-1:0] first_off(input logic [LANES-1:0] be, input logic big);
    logic [OW-1:0] r;
    r = '0;
    for (int o = LANES-1; o >= 0; o--)
      if (be[lane_of(OW'(o), big)]) r = OW'(o);
    return r;
  endfunction

  // sub-word slave address remap; size 0 byte, 1 halfword, else word
  function automatic logic [OW-1:0] slave_remap(input logic [OW-1:0] addr,
                                                input logic [1:0] size, input logic big);
    if (!big || size[1]) return addr;
    if (size == 2'd0) return addr ^ OW'(LANES-1);
    return addr ^ OW'(LANES-2);
  endfunction
endpackage

// File: rtl/elp_pack.sv
module elp_pack
  import elp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                big_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BW-1:0]       in_byte,
  input  logic                in_last,
  input  logic [OW-1:0]       in_start_off,
  output logic                pk_valid,
  input  logic                pk_ready,
  output logic [LANES*BW-1:0] pk_data,
  output logic [LANES-1:0]    pk_be,
  output logic                in_fire,
  output logic                word_done
);
  logic [LANES*BW-1:0] acc, d_m;
  logic [LANES-1:0]    acc_be, be_m;
  logic [OW-1:0]       nxt, off_e, lane;
  logic                busy, mode_r, mode_e;

  assign in_ready  = !pk_valid;
  assign in_fire   = in_valid && in_ready;
  assign mode_e    = busy ? mode_r : big_mode;
  assign off_e     = busy ? nxt : in_start_off;
  assign lane      = lane_of(off_e, mode_e);
  assign word_done = in_fire && ((off_e == OW'(LANES-1)) || in_last);

  always_comb begin
    d_m  = acc;
    be_m = acc_be;
    d_m[lane*BW +: BW] = in_byte;
    be_m[lane]         = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; acc_be <= '0; nxt <= '0; busy <= 1'b0; mode_r <= 1'b0;
      pk_valid <= 1'b0; pk_data <= '0; pk_be <= '0;
    end else begin
      if (pk_valid && pk_ready) pk_valid <= 1'b0;
      if (in_fire) begin
        mode_r <= mode_e;
        if (word_done) begin
          pk_valid <= 1'b1;
          pk_data  <= d_m;
          pk_be    <= be_m;
          acc      <= '0;
          acc_be   <= '0;
          nxt      <= '0;
          busy     <= !in_last;
        end else begin
          acc    <= d_m;
          acc_be <= be_m;
          nxt    <= off_e + OW'(1);
          busy   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/elp_unpack.sv
module elp_unpack
  import elp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                big_mode,
  input  logic                un_valid,
  output logic                un_ready,
  input  logic [LANES*BW-1:0] un_data,
  input  logic [LANES-1:0]    un_be,
  output logic                so_valid,
  input  logic                so_ready,
  output logic [BW-1:0]       so_byte,
  output logic                so_last,
  output logic                word_fire,
  output logic                byte_fire
);
  logic [LANES*BW-1:0] wd;
  logic [LANES-1:0]    rem;
  logic                mode_r;
  logic [OW-1:0]       cur_lane;

  assign un_ready  = ~|rem;
  assign word_fire = un_valid && un_ready;
  assign so_valid  = |rem;
  assign cur_lane  = lane_of(first_off(rem, mode_r), mode_r);
  assign so_byte   = wd[cur_lane*BW +: BW];
  assign so_last   = ($countones(rem) == 1);
  assign byte_fire = so_valid && so_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd <= '0; rem <= '0; mode_r <= 1'b0;
    end else if (word_fire) begin
      wd     <= un_data;
      rem    <= un_be;
      mode_r <= big_mode;
    end else if (byte_fire) begin
      rem[cur_lane] <= 1'b0;
    end
  end
endmodule

// File: rtl/elp_swizzle.sv
module elp_swizzle
  import elp_pkg::*;
(
  input  logic          big_mode,
  input  logic [OW-1:0] sl_addr,
  input  logic [1:0]    sl_size,
  output logic [OW-1:0] sl_lane_addr
);
  assign sl_lane_addr = slave_remap(sl_addr, sl_size, big_mode);
endmodule

// File: rtl/endian_lane_packer.sv
module endian_lane_packer
  import elp_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                big_mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BW-1:0]       in_byte,
  input  logic                in_last,
  input  logic [OW-1:0]       in_start_off,
  output logic                pk_valid,
  input  logic                pk_ready,
  output logic [LANES*BW-1:0] pk_data,
  output logic [LANES-1:0]    pk_be,
  input  logic                un_valid,
  output logic                un_ready,
  input  logic [LANES*BW-1:0] un_data,
  input  logic [LANES-1:0]    un_be,
  output logic                so_valid,
  input  logic                so_ready,
  output logic [BW-1:0]       so_byte,
  output logic                so_last,
  input  logic [OW-1:0]       sl_addr,
  input  logic [1:0]          sl_size,
  output logic [OW-1:0]       sl_lane_addr
);
  logic in_fire, word_done, word_fire, byte_fire;

  elp_pack u_pack (
    .clk, .rst, .big_mode, .in_valid, .in_ready, .in_byte, .in_last, .in_start_off,
    .pk_valid, .pk_ready, .pk_data, .pk_be, .in_fire, .word_done
  );

  elp_unpack u_unpack (
    .clk, .rst, .big_mode, .un_valid, .un_ready, .un_data, .un_be,
    .so_valid, .so_ready, .so_byte, .so_last, .word_fire, .byte_fire
  );

  elp_swizzle u_swz (.big_mode, .sl_addr, .sl_size, .sl_lane_addr);
endmodule

// File: rtl/elp_chk.sv
module elp_chk
  import elp_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                big_mode,
  input logic                in_ready,
  input logic                pk_valid,
  input logic                pk_ready,
  input logic [LANES*BW-1:0] pk_data,
  input logic [LANES-1:0]    pk_be,
  input logic                word_done,
  input logic                so_valid,
  input logic                so_ready,
  input logic [BW-1:0]       so_byte,
  input logic                so_last,
  input logic                byte_fire,
  input logic [OW-1:0]       sl_addr,
  input logic [1:0]          sl_size,
  input logic [OW-1:0]       sl_lane_addr
);
  AST_PK_HOLD: assert property (@(posedge clk) disable iff (rst)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_data) && $stable(pk_be)); // R9
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    pk_valid |-> !in_ready); // R9
  AST_WORD_EMIT: assert property (@(posedge clk) disable iff (rst)
    word_done |=> pk_valid && (pk_be != '0)); // R4
  AST_SO_HOLD: assert property (@(posedge clk) disable iff (rst)
    so_valid && !so_ready |=> so_valid && $stable(so_byte) && $stable(so_last)); // R9
  AST_SO_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    byte_fire && so_last |=> !so_valid); // R6
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
    sl_size[1] |-> sl_lane_addr == sl_addr); // R8
  AST_LITTLE_PASS: assert property (@(posedge clk) disable iff (rst)
    !big_mode |-> sl_lane_addr == sl_addr); // R8
endmodule

bind endian_lane_packer elp_chk u_chk (
  .clk, .rst, .big_mode, .in_ready, .pk_valid, .pk_ready, .pk_data, .pk_be, .word_done,
  .so_valid, .so_ready, .so_byte, .so_last, .byte_fire, .sl_addr, .sl_size, .sl_lane_addr
);

// File: tb/sim_endian_lane_packer.sv
`timescale 1ns/1ps
module sim_endian_lane_packer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic big_mode = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, pk_ready = 1'b1;
  logic [7:0] in_byte = '0;
  logic [1:0] in_start_off = '0;
  logic un_valid = 1'b0, so_ready = 1'b0;
  logic [31:0] un_data = '0;
  logic [3:0] un_be = '0;
  logic [1:0] sl_addr = '0, sl_size = '0;
  logic in_ready, pk_valid, un_ready, so_valid, so_last;
  logic [31:0] pk_data;
  logic [3:0] pk_be;
  logic [7:0] so_byte;
  logic [1:0] sl_lane_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  endian_lane_packer u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int blane(input int a, input bit big);
    return big ? (3 - a) : a;
  endfunction

  function automatic logic [1:0] bremap(input logic [1:0] a, input logic [1:0] sz, input bit big);
    if (!big) return a;
    case (sz)
      2'd0: return {~a[1], ~a[0]};
      2'd1: return {~a[1], a[0]};
      default: return a;
    endcase
  endfunction

  // inbound transfer: big orientation, start offset s, n bytes, stall cycles on each word
  task automatic pk_xfer(input bit big, input int s, input int n, input int stall, input bit flip);
    logic [31:0] ed;
    logic [3:0] eb;
    logic [7:0] b;
    int a;
    ed = '0; eb = '0; a = s;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      @(negedge clk);
      chk(in_ready === 1'b1, "R9 in_ready idle", 32'(in_ready), 1);
      big_mode = (i > 0 && flip) ? ~big : big;   // R7: late change ignored
      in_valid = 1'b1; in_byte = b; in_last = (i == n - 1);
      in_start_off = (i == 0) ? 2'(s) : 2'($urandom);  // R5: ignored after first byte
      ed[blane(a % 4, big)*8 +: 8] = b;
      eb[blane(a % 4, big)] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if ((a % 4 == 3) || (i == n - 1)) begin
        chk(pk_valid === 1'b1, "R4 word emitted", 32'(pk_valid), 1);
        chk(pk_data === ed, big ? "R3 big data" : "R2 little data", pk_data, ed);
        chk(pk_be === eb, "R4/R5 byte enables", 32'(pk_be), 32'(eb));
        if (stall > 0) begin
          pk_ready = 1'b0;
          for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(pk_valid === 1'b1 && pk_data === ed && pk_be === eb, "R9 hold", pk_data, ed);
            chk(in_ready === 1'b0, "R9 in_ready blocked", 32'(in_ready), 0);
          end
          pk_ready = 1'b1;
        end
        @(negedge clk);
        chk(pk_valid === 1'b0, "R4 word taken", 32'(pk_valid), 0);
        ed = '0; eb = '0;
      end else begin
        chk(pk_valid === 1'b0, "R4 no early word", 32'(pk_valid), 0);
      end
      a++;
    end
  endtask

  // outbound word
  task automatic un_word(input bit big, input logic [31:0] d, input logic [3:0] be, input bit flip);
    int cnt;
    int seen;
    bit r;
    logic [7:0] exp;
    cnt = $countones(be);
    seen = 0;
    @(negedge clk);
    chk(un_ready === 1'b1, "R9 un_ready idle", 32'(un_ready), 1);
    big_mode = big; un_valid = 1'b1; un_data = d; un_be = be;
    @(posedge clk);
    @(negedge clk);
    un_valid = 1'b0;
    if (flip) big_mode = ~big;  // R7
    for (int a = 0; a < 4; a++) begin
      if (be[blane(a, big)]) begin
        exp = d[blane(a, big)*8 +: 8];
        seen++;
        do begin
          chk(so_valid === 1'b1 && so_byte === exp, "R6 byte order", 32'(so_byte), 32'(exp));
          chk(so_last === (seen == cnt), "R6 so_last", 32'(so_last), 32'(seen == cnt));
          chk(un_ready === 1'b0, "R9 un_ready busy", 32'(un_ready), 0);
          r = ($urandom % 3) != 0;
          so_ready = r;
          @(posedge clk);
          @(negedge clk);
        end while (!r);
        so_ready = 1'b0;
      end
    end
    chk(so_valid === 1'b0, "R6 word drained", 32'(so_valid), 0);
    chk(un_ready === 1'b1, "R6 ready again", 32'(un_ready), 1);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(pk_valid === 1'b0 && so_valid === 1'b0, "R1 valids low", {pk_valid, so_valid}, 0);
    chk(in_ready === 1'b1 && un_ready === 1'b1, "R1 readys high", {in_ready, un_ready}, 3);

    // directed inbound
    pk_xfer(0, 0, 4, 0, 0);   // R2 full word
    pk_xfer(1, 0, 4, 0, 0);   // R3 full word
    pk_xfer(1, 2, 1, 0, 0);   // R5 single mid-word byte, R4 partial
    pk_xfer(0, 3, 6, 2, 1);   // R5/R7 spanning words with stall
    pk_xfer(1, 1, 9, 1, 1);   // R3/R7
    for (int t = 0; t < 25; t++)
      pk_xfer(1'($urandom), int'($urandom % 4), 1 + int'($urandom % 10),
              int'($urandom % 3), 1'($urandom));

    // directed outbound
    un_word(0, 32'h44332211, 4'b1111, 0);  // R6 little
    un_word(1, 32'h44332211, 4'b1111, 1);  // R6 big, R7
    un_word(1, 32'hA1B2C3D4, 4'b0101, 0);  // R6 skip lanes
    un_word(0, 32'hDEADBEEF, 4'b0000, 0);  // R6 empty word
    for (int t = 0; t < 25; t++)
      un_word(1'($urandom), $urandom, 4'($urandom), 1'($urandom));

    // slave remap, all combinations
    for (int m = 0; m < 2; m++)
      for (int z = 0; z < 4; z++)
        for (int a = 0; a < 4; a++) begin
          @(negedge clk);
          big_mode = 1'(m); sl_size = 2'(z); sl_addr = 2'(a);
          #1;
          chk(sl_lane_addr === bremap(2'(a), 2'(z), 1'(m)), "R8 remap",
              32'(sl_lane_addr), 32'(bremap(2'(a), 2'(z), 1'(m))));
        end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule